// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Status Block

This block is the shared event-collection and control register file for a 16-channel DMA engine. Each channel reports single-cycle pulses for a finished transfer, for a termination error and for a bus error. The block latches these pulses into status flags. It also holds the per-channel interrupt enables, the pause (freeze) bits and the one-shot channel reset requests that drive the channel datapaths.

Software reaches each of the three 32-bit registers through three addresses. The plain address replaces the contents. The set alias ORs the written ones into the register. The clear alias clears the written ones. A handler can read a status register and write that value back to the clear alias, which acknowledges exactly the events it saw.

The block sorts the latched flags into real errors and plain completions. A termination error that arrives together with a completion does not count as an error. From these flags it drives one interrupt line. It also gives the index of the most urgent pending event, so the handler can service that channel first. Errors rank above completions, and a higher channel number ranks above a lower one.

Top module: `dma_evt_status`

## Requirements
- R1: After reset, all three registers read zero, and `irq`, `pend_valid`, `freeze` and `chan_rst` are low.
- R2: Register bases are control 0x00, status-A 0x10 and status-B 0x20. A write to a base address replaces the whole 32-bit register, and a read of any of the three addresses of a register returns its current value. Writing 0xFFFF0000 to status-A enables interrupts on all 16 channels.
- R3: A write to base+0x4 ORs the write data into the register. A write to base+0x8 clears every bit that is 1 in the write data. All other bits keep their value.
- R4: A `ev_done[n]` pulse sets status-A bit n, where bits [15:0] hold the completion flags and bits [31:16] the interrupt enables. A `ev_term[n]` pulse sets status-B bit n. A `ev_bus[n]` pulse sets both status-B bit n and the qualifier bit n+16. Each flag is readable on the cycle after the pulse.
- R5: When an event pulse and a clear-alias write hit the same flag in the same cycle, the flag ends up set.
- R6: Channel n is in error when its qualifier and error flag are both set, or when its error flag is set while its qualifier and its completion flag are both clear.
- R7: `irq` is high exactly when some channel has both its completion flag and its enable set, or when some channel is in error.
- R8: Form the pending vector with the error bits in positions 31..16 and the completion flags in 15..0. Then `pend_valid` is high when this vector is nonzero, and `pend_idx` gives the position of its highest set bit.
- R9: Control bits [31:16] are reset requests. A request bit set by a write is driven on `chan_rst` for exactly one cycle and then clears itself. At the same edge it clears that channel's freeze bit.
- R10: `freeze` always equals control bits [15:0].
- R11: Writes to addresses other than the nine defined ones change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_done | input | 16 | Per-channel completion pulses |
| ev_term | input | 16 | Per-channel termination-error pulses |
| ev_bus | input | 16 | Per-channel bus-error pulses |
| irq | output | 1 | Combined interrupt |
| freeze | output | 16 | Per-channel pause |
| chan_rst | output | 16 | Per-channel one-cycle reset pulse |
| pend_valid | output | 1 | Some event is pending |
| pend_idx | output | 5 | Highest-ranked pending bit |

## Verification
The bench raises a termination error and a completion on the same channel in the same cycle. A design that ignored the completion would report an error there and rank the event in the upper half. It pulses a completion in the same cycle as a clear-alias write of all completion flags. A clear that wins would lose the event. It triggers a reset request on a frozen channel and watches `chan_rst` cycle by cycle: a sticky request would hold the channel in reset, and a missed side effect would leave the channel frozen. It also mixes pending bits across channels and types, and pokes holes in the address map, to catch encoders with the wrong direction and aliases that decode too loosely.

// File: rtl/dma_evt_status.sv
module dma_evt_status #(
  parameter int NCH = 16,
  parameter int AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [2*NCH-1:0]        bus_wdata,
  output logic [2*NCH-1:0]        bus_rdata,
  input  logic [NCH-1:0]          ev_done,
  input  logic [NCH-1:0]          ev_term,
  input  logic [NCH-1:0]          ev_bus,
  output logic                    irq,
  output logic [NCH-1:0]          freeze,
  output logic [NCH-1:0]          chan_rst,
  output logic                    pend_valid,
  output logic [$clog2(2*NCH)-1:0] pend_idx
);
  localparam int DW = 2 * NCH;
  localparam int IW = $clog2(DW);
  localparam logic [AW-1:0] A_CTL = AW'(8'h00);
  localparam logic [AW-1:0] A_STA = AW'(8'h10);
  localparam logic [AW-1:0] A_STB = AW'(8'h20);
  localparam logic [AW-1:0] O_SET = AW'(8'h04);
  localparam logic [AW-1:0] O_CLR = AW'(8'h08);

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_SET, OP_CLR} op_e;

  logic [DW-1:0] ctl_q, sta_q, stb_q;
  op_e op_ctl, op_sta, op_stb;

  function automatic op_e dec(input logic wr, input logic [AW-1:0] a, input logic [AW-1:0] base);
    if (!wr)              return OP_NONE;
    if (a == base)        return OP_WR;
    if (a == base + O_SET) return OP_SET;
    if (a == base + O_CLR) return OP_CLR;
    return OP_NONE;
  endfunction

  function automatic logic [DW-1:0] upd(input logic [DW-1:0] cur, input op_e op, input logic [DW-1:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  assign op_ctl = dec(bus_wr, bus_addr, A_CTL);
  assign op_sta = dec(bus_wr, bus_addr, A_STA);
  assign op_stb = dec(bus_wr, bus_addr, A_STB);

  wire [NCH-1:0] rst_q  = ctl_q[DW-1:NCH];
  wire [NCH-1:0] frz_q  = ctl_q[NCH-1:0];
  wire [NCH-1:0] done_q = sta_q[NCH-1:0];
  wire [NCH-1:0] ien_q  = sta_q[DW-1:NCH];
  wire [NCH-1:0] terr_q = stb_q[NCH-1:0];
  wire [NCH-1:0] qual_q = stb_q[DW-1:NCH];

  wire [DW-1:0] ctl_base = {{NCH{1'b0}}, frz_q & ~rst_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sta_q <= '0;
      stb_q <= '0;
    end else begin
      ctl_q <= upd(ctl_base, op_ctl, bus_wdata);
      sta_q <= upd(sta_q, op_sta, bus_wdata) | {{NCH{1'b0}}, ev_done};
      stb_q <= upd(stb_q, op_stb, bus_wdata) | {ev_bus, ev_term | ev_bus};
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL, A_CTL + O_SET, A_CTL + O_CLR: bus_rdata = ctl_q;
      A_STA, A_STA + O_SET, A_STA + O_CLR: bus_rdata = sta_q;
      A_STB, A_STB + O_SET, A_STB + O_CLR: bus_rdata = stb_q;
      default:                             bus_rdata = '0;
    endcase
  end

  wire [NCH-1:0] err_eff = (qual_q & terr_q) | (~qual_q & terr_q & ~done_q);
  wire [DW-1:0]  pvec    = {err_eff, done_q};

  assign irq      = (|(done_q & ien_q)) | (|err_eff);
  assign freeze   = frz_q;
  assign chan_rst = rst_q;
  assign pend_valid = |pvec;

  always_comb begin
    pend_idx = '0;
    for (int i = 0; i < DW; i++)
      if (pvec[i]) pend_idx = IW'(i);
  end

  p_pend_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((pvec >> pend_idx) == DW'(1)));

  p_err_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && (pend_idx >= IW'(NCH))) |-> irq);

  p_evt_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_done) |=> ((done_q & $past(ev_done)) == $past(ev_done)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sta == OP_CLR && ev_done == '0) |=> ((done_q & $past(bus_wdata[NCH-1:0])) == '0));

  p_rst_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_rst) && !bus_wr) |=> (chan_rst == '0 && (freeze & $past(chan_rst)) == '0));
endmodule

// File: tb/sim_dma_evt_status.sv
module sim_dma_evt_status;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] ev_done = 0, ev_term = 0, ev_bus = 0;
  logic        irq, pend_valid;
  logic [15:0] freeze, chan_rst;
  logic [4:0]  pend_idx;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  dma_evt_status u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .ev_done, .ev_term, .ev_bus, .irq, .freeze, .chan_rst, .pend_valid, .pend_idx);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(logic [15:0] d, logic [15:0] t, logic [15:0] b);
    @(negedge clk); ev_done = d; ev_term = t; ev_bus = b;
    @(negedge clk); ev_done = 0; ev_term = 0; ev_bus = 0;
  endtask

  task automatic clear_all();
    wr(6'h00, 0); wr(6'h10, 0); wr(6'h20, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 ctl", v, 0);
    rd(6'h10, v); chk("R1 stA", v, 0);
    rd(6'h20, v); chk("R1 stB", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pend_valid", {31'b0, pend_valid}, 0);
    chk("R1 freeze/rst", {freeze, chan_rst}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(6'h00, 32'h0000_00A5);
    rd(6'h08, v); chk("R2 ctl readback via alias", v, 32'h0000_00A5);
    chk("R10 freeze", {16'b0, freeze}, 32'h00A5);
    wr(6'h10, 32'hFFFF_0000);
    rd(6'h14, v); chk("R2 enable all", v, 32'hFFFF_0000);
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h30, 32'hFFFF_FFFF); wr(6'h1C, 0);
    rd(6'h00, v); chk("R11 ctl untouched", v, 32'h0000_00A5);
    rd(6'h10, v); chk("R11 stA untouched", v, 32'hFFFF_0000);
    rd(6'h20, v); chk("R11 stB untouched", v, 0);
    clear_all();
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(6'h14, 32'h00F0_0003);
    rd(6'h10, v); chk("R3 set alias", v, 32'h00F0_0003);
    wr(6'h18, 32'h0010_0001);
    rd(6'h10, v); chk("R3 clear alias", v, 32'h00E0_0002);
    clear_all();
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(6'h10, 32'hFFFF_0000);
    pulse(16'h0008, 0, 0);
    rd(6'h10, v); chk("R4 done flag", v, 32'hFFFF_0008);
    chk("R7 irq on enabled done", {31'b0, irq}, 1);
    chk("R8 idx done3", {27'b0, pend_idx}, 3);
    pulse(0, 16'h0020, 0);
    rd(6'h20, v); chk("R4 term flag", v, 32'h0000_0020);
    chk("R6/R8 term err ch5", {27'b0, pend_idx}, 21);
    pulse(0, 0, 16'h0004);
    rd(6'h20, v); chk("R4 bus err sets both", v, 32'h0004_0024);
    chk("R8 highest err wins", {27'b0, pend_idx}, 21);
    wr(6'h28, v);
    rd(6'h20, v); chk("R3 readback ack", v, 0);
    chk("R8 back to done3", {27'b0, pend_idx}, 3);
    clear_all();
  endtask

  task automatic t_term_done();
    logic [31:0] v;
    pulse(16'h0080, 16'h0080, 0);
    chk("R6 term+done not error irq", {31'b0, irq}, 0);
    chk("R6 idx is completion", {26'b0, pend_valid, pend_idx}, {26'b0, 1'b1, 5'd7});
    pulse(0, 0, 16'h0080);
    chk("R6 bus err is error", {27'b0, pend_idx}, 23);
    chk("R7 irq on error", {31'b0, irq}, 1);
    rd(6'h20, v); chk("R4 stB", v, 32'h0080_0080);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(6'h14, 32'h0000_0002);
    @(negedge clk); bus_wr = 1; bus_addr = 6'h18; bus_wdata = 32'h0000_FFFF; ev_done = 16'h0200;
    @(negedge clk); bus_wr = 0; ev_done = 0;
    rd(6'h10, v); chk("R5 event beats clear", v, 32'h0000_0200);
    clear_all();
  endtask

  task automatic t_irq_mask();
    pulse(16'h1003, 0, 0);
    chk("R7 no enable no irq", {31'b0, irq}, 0);
    chk("R8 idx 12 over 1/0", {27'b0, pend_idx}, 12);
    wr(6'h14, 32'h0004_0000);
    chk("R7 other enable no irq", {31'b0, irq}, 0);
    wr(6'h14, 32'h0002_0000);
    chk("R7 matching enable irq", {31'b0, irq}, 1);
    clear_all();
  endtask

  task automatic t_rst_pulse();
    logic [31:0] v;
    wr(6'h04, 32'h0000_0030);
    @(negedge clk); bus_wr = 1; bus_addr = 6'h04; bus_wdata = 32'h0010_0000;
    @(negedge clk); bus_wr = 0;
    chk("R9 pulse high", {16'b0, chan_rst}, 32'h0010);
    chk("R10 freeze still", {16'b0, freeze}, 32'h0030);
    @(negedge clk);
    chk("R9 pulse one cycle", {16'b0, chan_rst}, 0);
    chk("R9 freeze cleared ch4", {16'b0, freeze}, 32'h0020);
    rd(6'h00, v); chk("R9 ctl read", v, 32'h0000_0020);
    clear_all();
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_alias();
    t_events();
    t_term_done();
    t_set_wins();
    t_irq_mask();
    t_rst_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule